// File: doc/BRIEF.md
# Polled Pseudo-DMA Handshake Engine

This block takes the place of a DMA controller on the DMA port of a peripheral that has a data FIFO. Software supplies a direction, a start address in a local synchronous memory and a byte count, then pulses `start`. The engine then repeats a fixed loop. It samples the peripheral's request line. While the request is low, it keeps waiting. When the request is high, it raises acknowledge together with exactly one data strobe for one cycle, moves one byte between the port and memory, advances its pointer and goes back to sampling.

The peripheral's interrupt, not the engine's own count, ends a transfer. That interrupt may arrive some cycles after the last byte. Once the programmed number of bytes has moved, the engine keeps polling but moves no more data until the interrupt comes. If the interrupt arrives early, the engine reports a short transfer. A stall timer, cleared at start and after every byte, ends a transfer that makes no progress and reports a stall error. Register accesses by the host (chip select) pass through the engine and are blocked while acknowledge is active.

Top module: `pdma_engine`

## Requirements
- R1: `port_ack` is high only in a cycle whose previous cycle sampled `port_req` high while the engine was busy; a low request never produces an acknowledge.
- R2: Every acknowledge cycle carries exactly one strobe. `port_rd` is used when `dir_to_mem`=1 (port to memory) and `port_wr` when `dir_to_mem`=0 (memory to port). Neither strobe is active without acknowledge.
- R3: `port_cs` follows `host_cs`, but is forced low in every cycle where `port_ack` is high.
- R4: Byte k of a transfer uses memory address `base_addr`+k. With `dir_to_mem`=1, `port_rdata` in the acknowledge cycle is written to memory (`mem_we`). With `dir_to_mem`=0, memory is read (`mem_re`) in the cycle before the acknowledge, and `port_wdata` carries that byte during the acknowledge.
- R5: Acknowledge lasts one cycle. It is followed by at least one cycle without acknowledge before the request is sampled again, so each byte takes at least three cycles.
- R6: Once `moved_count` equals `byte_count` (including a count of 0), no further acknowledge occurs whatever the request does, and `busy` stays high until the interrupt or the timeout.
- R7: A high `port_irq` in any busy cycle is remembered. At the next polling cycle it ends the transfer: `busy` falls, `done` is set, and `short_xfer` is set if `moved_count` differs from `byte_count`. The interrupt takes priority over both the timeout and the request.
- R8: The stall counter clears at start and after each byte. It counts every other busy cycle up to `timeout_limit`. In a polling cycle where it has reached `timeout_limit` and no interrupt is pending, the transfer ends with `stall_err` set and `done` clear.
- R9: `start` is acted on only while idle. A start clears `done`, `stall_err`, `short_xfer` and `moved_count`. A start while busy has no effect.
- R10: After reset, `busy`, `port_ack`, the strobes, the memory enables and all status flags are low and `moved_count` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a transfer (taken only while idle) |
| dir_to_mem | input | 1 | 1: port to memory, 0: memory to port |
| base_addr | input | AW | First memory address |
| byte_count | input | CW | Number of bytes expected |
| timeout_limit | input | TW | Stall limit in cycles |
| host_cs | input | 1 | Host register-access select request |
| port_req | input | 1 | Peripheral request line |
| port_irq | input | 1 | Peripheral interrupt |
| port_rdata | input | DW | Byte from the peripheral FIFO |
| port_ack | output | 1 | Acknowledge to the peripheral |
| port_rd | output | 1 | Read strobe to the peripheral |
| port_wr | output | 1 | Write strobe to the peripheral |
| port_cs | output | 1 | Chip select to the peripheral |
| port_wdata | output | DW | Byte to the peripheral FIFO |
| mem_addr | output | AW | Memory address |
| mem_re | output | 1 | Memory read enable (data one cycle later) |
| mem_we | output | 1 | Memory write enable |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Ended by interrupt |
| stall_err | output | 1 | Ended by stall timeout |
| short_xfer | output | 1 | Interrupt came with a count mismatch |
| moved_count | output | CW | Bytes moved in this transfer |

## Verification
The assertions check on every cycle the local handshake rules. An acknowledge comes only after a sampled request and always carries exactly one strobe. An acknowledge never lasts two cycles. No byte moves past the programmed count. A stall flag rises only from an expired timer, and the status flags are never set while busy. Only the bench's scenarios can show the data ordering against memory and the peripheral, the exact cycle at which a timeout fires, and a start being ignored mid-transfer. The same applies to the lagging interrupt after a full count, to the short-transfer report, and to chip-select blocking under a host request. The bench covers these by running its cycle model through back-to-back transfers with steady, random and stopped request patterns.

// File: rtl/pdma_pkg.sv
// Shared types for the pseudo-DMA handshake engine.
package pdma_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,   // waiting for start
        ST_POLL = 2'd1,   // sampling request / interrupt / timer
        ST_XFER = 2'd2,   // acknowledge + strobe, one byte moves
        ST_GAP  = 2'd3    // mandatory quiet cycle after a byte
    } pdma_state_e;
endpackage

// File: rtl/pdma_timer.sv
// Stall timer: latches the limit at load, clears on load and after each
// byte, and counts the other busy cycles, saturating at the limit.
// Assumes: the limit is held only through the load cycle.
module pdma_timer #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          step,
    input  logic          run,
    input  logic [TW-1:0] limit,
    output logic          expired
);
    logic [TW-1:0] cnt;
    logic [TW-1:0] lim_q;

    // Purpose: hold the programmed stall limit for the whole transfer.
    always_ff @(posedge clk) begin
        if (!rst_n)    lim_q <= '0;
        else if (load) lim_q <= limit;
    end

    // Purpose: count idle busy cycles since the last start or byte.
    always_ff @(posedge clk) begin
        if (!rst_n)                     cnt <= '0;
        else if (load || step)          cnt <= '0;
        else if (run && (cnt < lim_q))  cnt <= cnt + 1'b1;
    end

    assign expired = (cnt >= lim_q);
endmodule

// File: rtl/pdma_ptr.sv
// Buffer pointer and byte counter: loads the base address and target
// count at start and advances both by one per moved byte.
// Assumes: step is never raised once the count is reached.
module pdma_ptr #(
    parameter int AW = 16,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          step,
    input  logic [AW-1:0] base,
    input  logic [CW-1:0] count,
    output logic [AW-1:0] addr,
    output logic [CW-1:0] moved,
    output logic          full
);
    logic [CW-1:0] target;

    // Purpose: load pointer/target at start, advance on each byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr   <= '0;
            moved  <= '0;
            target <= '0;
        end else if (load) begin
            addr   <= base;
            moved  <= '0;
            target <= count;
        end else if (step) begin
            addr   <= addr + 1'b1;
            moved  <= moved + 1'b1;
        end
    end

    assign full = (moved == target);

    AST_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
        moved <= target);                                    // R6
    AST_STEP_NOT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> !full);                                     // R6
endmodule

// File: rtl/pdma_ctrl.sv
// Handshake sequencer: idle -> poll -> (acknowledge -> gap -> poll)* and
// back to idle on interrupt or stall. Keeps status flags and the latched
// direction. Assumes the interrupt is a level that may lag the last byte.
module pdma_ctrl
    import pdma_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        dir_in,
    input  logic        req,
    input  logic        irq,
    input  logic        expired,
    input  logic        full,
    output pdma_state_e state,
    output logic        dir_q,
    output logic        load,
    output logic        step,
    output logic        fetch,
    output logic        busy,
    output logic        done,
    output logic        stall_err,
    output logic        short_xfer
);
    logic irq_pend;
    logic irq_now;
    logic go;

    // Purpose: decode the poll decision and the per-cycle strobes.
    always_comb begin
        irq_now = irq || irq_pend;
        go      = (state == ST_POLL) && !irq_now && !expired && req && !full;
        load    = (state == ST_IDLE) && start;
        step    = (state == ST_XFER);
        fetch   = go && !dir_q;
        busy    = (state != ST_IDLE);
    end

    // Purpose: advance the handshake state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE: if (start) state <= ST_POLL;
                ST_POLL: begin
                    if (irq_now || expired) state <= ST_IDLE;
                    else if (go)            state <= ST_XFER;
                end
                ST_XFER: state <= ST_GAP;
                ST_GAP:  state <= ST_POLL;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Purpose: latch direction at start and remember an early interrupt.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q    <= 1'b0;
            irq_pend <= 1'b0;
        end else if (load) begin
            dir_q    <= dir_in;
            irq_pend <= 1'b0;
        end else if (busy && irq) begin
            irq_pend <= 1'b1;
        end
    end

    // Purpose: completion status, cleared by each accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n || load) begin
            done       <= 1'b0;
            stall_err  <= 1'b0;
            short_xfer <= 1'b0;
        end else if (state == ST_POLL) begin
            if (irq_now) begin
                done       <= 1'b1;
                short_xfer <= !full;
            end else if (expired) begin
                stall_err  <= 1'b1;
            end
        end
    end

    AST_ACK_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_XFER) |-> $past(req));                  // R1
    AST_STALL_FROM_TIMER: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stall_err) |-> $past(expired));                // R8
    AST_FLAGS_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (done || stall_err || short_xfer) |-> !busy);        // R7
endmodule

// File: rtl/pdma_engine.sv
// Polled pseudo-DMA handshake engine (top). Wires the sequencer, the
// pointer/counter and the stall timer, and drives port and memory pins.
// Assumes: memory has one-cycle read latency; the peripheral FIFO is
// accessed only while acknowledge and a strobe are both active.
module pdma_engine
    import pdma_pkg::*;
#(
    parameter int DW = 8,
    parameter int AW = 16,
    parameter int CW = 16,
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          dir_to_mem,
    input  logic [AW-1:0] base_addr,
    input  logic [CW-1:0] byte_count,
    input  logic [TW-1:0] timeout_limit,
    input  logic          host_cs,
    input  logic          port_req,
    input  logic          port_irq,
    input  logic [DW-1:0] port_rdata,
    output logic          port_ack,
    output logic          port_rd,
    output logic          port_wr,
    output logic          port_cs,
    output logic [DW-1:0] port_wdata,
    output logic [AW-1:0] mem_addr,
    output logic          mem_re,
    output logic          mem_we,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    output logic          busy,
    output logic          done,
    output logic          stall_err,
    output logic          short_xfer,
    output logic [CW-1:0] moved_count
);
    pdma_state_e state;
    logic        dir_q, load, step, fetch, expired, full;

    pdma_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .dir_in(dir_to_mem),
        .req(port_req), .irq(port_irq), .expired(expired), .full(full),
        .state(state), .dir_q(dir_q), .load(load), .step(step),
        .fetch(fetch), .busy(busy), .done(done), .stall_err(stall_err),
        .short_xfer(short_xfer)
    );

    pdma_ptr #(.AW(AW), .CW(CW)) u_ptr (
        .clk(clk), .rst_n(rst_n), .load(load), .step(step),
        .base(base_addr), .count(byte_count), .addr(mem_addr),
        .moved(moved_count), .full(full)
    );

    pdma_timer #(.TW(TW)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(load), .step(step), .run(busy),
        .limit(timeout_limit), .expired(expired)
    );

    // Purpose: drive handshake, strobes and the data paths.
    always_comb begin
        port_ack   = (state == ST_XFER);
        port_rd    = port_ack && dir_q;
        port_wr    = port_ack && !dir_q;
        port_cs    = host_cs && !port_ack;
        port_wdata = mem_rdata;
        mem_we     = port_ack && dir_q;
        mem_wdata  = port_rdata;
        mem_re     = fetch;
    end

    AST_ACK_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        port_ack |-> (port_rd != port_wr));                  // R2
    AST_STROBE_NEEDS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (port_rd || port_wr) |-> port_ack);                  // R2
    AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        port_ack |=> !port_ack);                             // R5
    AST_WRITE_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> port_ack);                                // R4
endmodule

// File: tb/tb_pdma_engine.sv
module tb_pdma_engine;
    localparam int DW = 8, AW = 16, CW = 16, TW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic          start = 0, dir_to_mem = 0, host_cs = 0;
    logic          port_req = 0, port_irq = 0;
    logic [AW-1:0] base_addr = '0;
    logic [CW-1:0] byte_count = '0;
    logic [TW-1:0] timeout_limit = '0;
    logic [DW-1:0] port_rdata, port_wdata, mem_wdata, mem_rdata;
    logic          port_ack, port_rd, port_wr, port_cs;
    logic [AW-1:0] mem_addr;
    logic          mem_re, mem_we, busy, done, stall_err, short_xfer;
    logic [CW-1:0] moved_count;

    pdma_engine #(.DW(DW), .AW(AW), .CW(CW), .TW(TW)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .dir_to_mem(dir_to_mem),
        .base_addr(base_addr), .byte_count(byte_count),
        .timeout_limit(timeout_limit), .host_cs(host_cs),
        .port_req(port_req), .port_irq(port_irq), .port_rdata(port_rdata),
        .port_ack(port_ack), .port_rd(port_rd), .port_wr(port_wr),
        .port_cs(port_cs), .port_wdata(port_wdata), .mem_addr(mem_addr),
        .mem_re(mem_re), .mem_we(mem_we), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .busy(busy), .done(done),
        .stall_err(stall_err), .short_xfer(short_xfer),
        .moved_count(moved_count)
    );

    int checks = 0;
    int fails  = 0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] rd_pat(input int k);
        return 8'(8'hA5 ^ (k * 29));
    endfunction
    function automatic logic [7:0] init_pat(input int a);
        return 8'(8'h3C + a * 7);
    endfunction

    // Peripheral and memory models
    int ack_cnt = 0;
    logic [7:0] mem [256];
    logic [7:0] wr_log [$];
    assign port_rdata = rd_pat(ack_cnt);

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) mem[i] <= init_pat(i);
            mem_rdata <= '0;
        end else begin
            if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
            if (mem_re) mem_rdata <= mem[mem_addr[7:0]];
        end
        if (port_ack) ack_cnt <= ack_cnt + 1;
        if (port_wr) wr_log.push_back(port_wdata);
    end

    // Behavioural cycle model: 0 idle, 1 polling, 2 acknowledging, 3 quiet
    int m_st = 0, m_dir = 0, m_addr = 0, m_moved = 0, m_target = 0;
    int m_cnt = 0, m_lim = 0;
    bit m_irqp = 0, m_done = 0, m_stall = 0, m_short = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_dir = 0; m_addr = 0; m_moved = 0; m_target = 0;
            m_cnt = 0; m_lim = 0; m_irqp = 0; m_done = 0; m_stall = 0; m_short = 0;
        end else begin
            bit was_busy;
            was_busy = (m_st != 0);
            if (m_st == 0) begin
                if (start) begin
                    m_st = 1; m_dir = int'(dir_to_mem); m_addr = int'(base_addr);
                    m_moved = 0; m_target = int'(byte_count); m_lim = int'(timeout_limit);
                    m_cnt = 0; m_irqp = 0; m_done = 0; m_stall = 0; m_short = 0;
                end
            end else begin
                if (port_irq) m_irqp = 1;
                case (m_st)
                    1: begin
                        if (port_irq || m_irqp_prev()) begin
                            m_done = 1; m_short = (m_moved != m_target); m_st = 0;
                        end else if (m_cnt >= m_lim) begin
                            m_stall = 1; m_st = 0;
                        end else if (port_req && m_moved != m_target) begin
                            m_st = 2;
                        end
                        if (m_cnt < m_lim) m_cnt++;
                    end
                    2: begin
                        m_addr++; m_moved++; m_cnt = 0; m_st = 3;
                    end
                    default: begin
                        m_st = 1;
                        if (m_cnt < m_lim) m_cnt++;
                    end
                endcase
            end
            m_irqp_q = (m_st == 0) ? 1'b0 : m_irqp;
            if (!was_busy) m_irqp_q = 0;
        end
    end

    // pending interrupt as it stood before this edge
    bit m_irqp_q = 0;
    function automatic bit m_irqp_prev();
        return m_irqp_q;
    endfunction

    // Per-cycle comparison, away from the edge
    always @(posedge clk) begin
        #2;
        if (rst_n) begin
            bit ack_e, re_e;
            ack_e = (m_st == 2);
            re_e  = (m_st == 1) && !(port_irq || m_irqp_q) && !(m_cnt >= m_lim)
                    && port_req && (m_moved != m_target) && (m_dir == 0);
            chk(port_ack == ack_e, "R1 ack timing", port_ack, ack_e);
            chk(port_rd == (ack_e && m_dir == 1) && port_wr == (ack_e && m_dir == 0),
                "R2 strobes", {port_rd, port_wr}, {ack_e && m_dir == 1, ack_e && m_dir == 0});
            chk(port_cs == (host_cs && !ack_e), "R3 chip select", port_cs, host_cs && !ack_e);
            chk(mem_re == re_e && mem_we == (ack_e && m_dir == 1), "R4 memory enables",
                {mem_re, mem_we}, {re_e, ack_e && m_dir == 1});
            if (ack_e) chk(int'(mem_addr) == m_addr, "R4 address", mem_addr, m_addr);
            chk(busy == (m_st != 0), "R7 busy", busy, m_st != 0);
            chk(done == m_done && short_xfer == m_short, "R7 status",
                {done, short_xfer}, {m_done, m_short});
            chk(stall_err == m_stall, "R8 stall flag", stall_err, m_stall);
            chk(int'(moved_count) == m_moved, "R6 moved count", moved_count, m_moved);
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic kick(input bit d, input int base, input int cnt, input int lim);
        @(negedge clk);
        start = 1; dir_to_mem = d; base_addr = AW'(base);
        byte_count = CW'(cnt); timeout_limit = TW'(lim);
        @(negedge clk);
        start = 0;
    endtask

    task automatic wait_moved(input int n);
        while (int'(moved_count) != n) @(negedge clk);
    endtask

    task automatic pulse_irq();
        @(negedge clk); port_irq = 1;
        @(negedge clk); port_irq = 0;
        tick(3);
    endtask

    initial begin
        tick(3);
        rst_n = 1;
        @(posedge clk); #2;
        // R10: reset state
        chk(!busy && !port_ack && !port_rd && !port_wr && !mem_re && !mem_we,
            "R10 reset outputs", {busy, port_ack, mem_re, mem_we}, 0);
        chk(!done && !stall_err && !short_xfer && moved_count == 0,
            "R10 reset status", {done, stall_err, short_xfer}, 0);

        // Port-to-memory, steady request, start while busy, lagging interrupt
        begin
            int a0;
            a0 = ack_cnt;
            port_req = 1;
            kick(1, 'h10, 4, 50);
            wait_moved(2);
            start = 1; dir_to_mem = 0; base_addr = 'h80; byte_count = 3;
            @(negedge clk); start = 0;
            wait_moved(4);
            tick(6);
            chk(ack_cnt - a0 == 4, "R6 no ack past count", ack_cnt - a0, 4);
            chk(busy == 1, "R6 busy awaiting irq", busy, 1);
            pulse_irq();
            port_req = 0;
            chk(done && !short_xfer && !stall_err, "R7 clean finish",
                {done, short_xfer, stall_err}, 3'b100);
            chk(moved_count == 4, "R9 busy start ignored", moved_count, 4);
            chk(mem['h80] == init_pat('h80), "R9 ignored start no access", mem['h80], init_pat('h80));
            for (int k = 0; k < 4; k++)
                chk(mem['h10 + k] == rd_pat(a0 + k), "R4 port to memory data",
                    mem['h10 + k], rd_pat(a0 + k));
        end

        // Memory-to-port, random request, host chip select held
        begin
            int w0;
            logic [7:0] lfsr;
            lfsr = 8'hB7;
            w0 = wr_log.size();
            host_cs = 1;
            kick(0, 'h40, 5, 1000);
            while (int'(moved_count) != 5) begin
                @(negedge clk);
                port_req = lfsr[0];
                lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            end
            port_req = 0;
            tick(2);
            pulse_irq();
            host_cs = 0;
            chk(wr_log.size() - w0 == 5, "R2 write strobes", wr_log.size() - w0, 5);
            for (int k = 0; k < 5; k++)
                if (w0 + k < wr_log.size())
                    chk(wr_log[w0 + k] == init_pat('h40 + k), "R4 memory to port data",
                        wr_log[w0 + k], init_pat('h40 + k));
            chk(done && !short_xfer, "R7 write finish", {done, short_xfer}, 2'b10);
        end

        // Early interrupt gives short transfer
        port_req = 1;
        kick(1, 'h20, 6, 100);
        wait_moved(3);
        port_req = 0;
        tick(4);
        pulse_irq();
        chk(done && short_xfer && moved_count == 3, "R7 short transfer",
            {done, short_xfer, moved_count}, {2'b11, 16'd3});

        // Stalled target: no request, no interrupt
        kick(1, 'h30, 2, 20);
        tick(40);
        chk(stall_err && !done && !busy, "R8 stall ends transfer",
            {stall_err, done, busy}, 3'b100);
        chk(moved_count == 0, "R8 nothing moved", moved_count, 0);

        // Zero count: request high but nothing moves, then interrupt
        begin
            int a0;
            a0 = ack_cnt;
            port_req = 1;
            kick(1, 'h50, 0, 200);
            chk(!stall_err && !done, "R9 start clears status", {stall_err, done}, 0);
            tick(10);
            chk(ack_cnt == a0 && busy, "R6 zero count no ack", ack_cnt - a0, 0);
            pulse_irq();
            port_req = 0;
            chk(done && !short_xfer, "R7 zero count finish", {done, short_xfer}, 2'b10);
        end

        // Stall after bytes: timer restarts after each byte
        port_req = 1;
        kick(1, 'h60, 8, 12);
        wait_moved(2);
        port_req = 0;
        tick(30);
        chk(stall_err && moved_count == 2, "R8 stall after bytes",
            {stall_err, moved_count}, {1'b1, 16'd2});

        tick(3);
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end
endmodule